// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes one asynchronous serial input and recovers characters from it using a 16x oversample tick. Each frame has one low start bit and eight data bits, least significant first. An optional extra bit follows the data. It is either a parity bit or, in nine-bit mode, a ninth data bit. One stop bit ends the frame. The recovered character goes into a single-entry receive buffer. A full flag marks the buffer as occupied until the consumer pulses the buffer read strobe.

Errors are reported on sticky flags: parity mismatch, missing stop bit and overrun. A combined error flag is the OR of the three. A status read strobe clears all of them. A line break is recognised when the line stays low for ten bit times after a frame ended without its stop bit. That flag is cleared by a status read if the line is already idle. Otherwise it clears when the line goes idle again after such a read.

An attention mode supports multi-drop links in nine-bit mode. While it is active, characters whose ninth bit is 0 are dropped. The first character whose ninth bit is 1 (an address character) is accepted, and it turns attention mode off.

Top module: `usart_rx`

## Requirements
- R1: A start is confirmed only if the line is still low on the 8th tick after the falling edge is seen. After that, each bit is sampled once every 16 ticks. The data arrives LSB first on `rx_data_o`, and `rbuf_full_o` is set. A low pulse that ends before the confirming tick produces no character.
- R2: With `par_en_i`=1 and nine-bit mode off, the bit after the data is checked against `par_sel_i`. The encodings are: 2'b00 odd parity, 2'b01 even parity, 2'b10 expects 0, 2'b11 expects 1. A mismatch sets `par_err_o`.
- R3: With `nine_bit_i`=1, the bit after the data is a ninth data bit. It is shown on `rx_bit9_o` for the last accepted character, and no parity is checked. In eight-bit mode `rx_bit9_o` reads 0.
- R4: A stop bit sampled low sets `frm_err_o`. The character is still stored.
- R5: If a character is stored while `rbuf_full_o` is set and no buffer read happens in that cycle, `ovr_err_o` is set.
- R6: A `stat_rd_i` pulse clears `par_err_o`, `frm_err_o` and `ovr_err_o`. `any_err_o` equals their OR.
- R7: An error that occurs in the same cycle as a status read stays set.
- R8: `brk_det_o` is set when the line stays low for 10 bit times (160 ticks) after a stop bit sampled low. A shorter low does not set it.
- R9: A status read while the line is high clears `brk_det_o` at once. A status read while the line is low leaves the flag set, and it then clears when the line returns high. Without a read, the flag stays set even after the line returns high.
- R10: A `rbuf_rd_i` pulse clears `rbuf_full_o`.
- R11: `atn_set_i` sets `atn_mode_o`. While it is set in nine-bit mode, a character with ninth bit 0 is dropped and leaves the buffer and flags untouched. A character with ninth bit 1 is stored and clears `atn_mode_o`.
- R12: After reset, all flags are 0, `atn_mode_o` is 0 and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, already synchronous to clk |
| os_tick_i | input | 1 | Oversample tick, 16 per bit time |
| par_en_i | input | 1 | Enables the parity bit and its check |
| par_sel_i | input | 2 | Parity kind, encoded as in R2 |
| nine_bit_i | input | 1 | Nine-bit character mode |
| atn_set_i | input | 1 | Pulse that turns attention mode on |
| rbuf_rd_i | input | 1 | Pulse marking that the receive buffer was read |
| stat_rd_i | input | 1 | Pulse marking that the status flags were read |
| rx_data_o | output | DATA_BITS (8) | Receive buffer contents |
| rx_bit9_o | output | 1 | Ninth bit of the last stored character |
| rbuf_full_o | output | 1 | Receive buffer holds an unread character |
| par_err_o | output | 1 | Parity error flag |
| frm_err_o | output | 1 | Framing error flag |
| ovr_err_o | output | 1 | Overrun flag |
| any_err_o | output | 1 | OR of the three error flags |
| brk_det_o | output | 1 | Line break detected |
| atn_mode_o | output | 1 | Attention mode is active |

## Verification
Characters are sent with every parity encoding, once with the correct parity bit and once with it inverted. This separates the odd and even encodings from the two constant ones and confirms that each one really checks. Nine-bit characters are sent with parity enabled to show that the extra bit becomes data and is never checked. Inside attention mode, address and non-address characters tell dropping apart from accepting. A bad stop bit is followed by lows of two lengths, which separates a plain framing error from a break. Status reads are issued with the line low and with it high to tell the immediate clear from the deferred one. A status read is also timed onto the exact cycle in which a new framing error and an overrun arrive, to show that new events survive the clear.

// File: rtl/usart_rx_pkg.sv
// Package: shared types for the serial receiver.
// Assumes: parity selection uses the two-bit encoding listed in the brief.
package usart_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_BREAK
    } rx_state_e;

    // Returns the parity bit the sender should have put on the line.
    // ones_odd: 1 when the data bits contain an odd number of ones.
    function automatic logic par_expected(input logic ones_odd, input logic [1:0] sel);
        logic r;
        case (sel)
            2'b00:   r = ~ones_odd;
            2'b01:   r = ones_odd;
            2'b10:   r = 1'b0;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/urx_sampler.sv
// Module: urx_sampler
// Confirms start bits, samples the data bits, the optional extra bit and the
// stop bit at mid-bit, then raises a one-cycle frame-done pulse. After a
// missing stop bit it times how long the line stays low and pulses brk_hit
// once the low has lasted BREAK_BITS bit times.
// Assumes: rx is already synchronous to clk and tick is a one-cycle pulse.
module urx_sampler
    import usart_rx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int DATA_BITS  = 8,
    parameter int BREAK_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx,
    input  logic                 tick,
    input  logic                 par_en,
    input  logic                 nine_bit,
    output logic                 frm_done,
    output logic [DATA_BITS-1:0] frm_data,
    output logic                 frm_ext,
    output logic                 frm_nine,
    output logic                 frm_par,
    output logic                 frm_stop_ok,
    output logic                 brk_hit
);
    localparam int CW        = $clog2(OVS);
    localparam int IW        = $clog2(DATA_BITS + 1);
    localparam int BRK_TICKS = BREAK_BITS * OVS;
    localparam int BW        = $clog2(BRK_TICKS + 1);
    localparam logic [CW-1:0] MID    = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
    localparam logic [IW-1:0] LAST_D = IW'(DATA_BITS - 1);
    localparam logic [IW-1:0] LAST_E = IW'(DATA_BITS);
    localparam logic [BW-1:0] BRK_END = BW'(BRK_TICKS - 1);

    rx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [IW-1:0]      idx;
    logic [DATA_BITS:0] bits;
    logic               has_ext;
    logic               nine_l;
    logic [BW-1:0]      brk_cnt;
    logic               brk_done;

    // Frame sequencing, bit capture and break timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cnt         <= '0;
            idx         <= '0;
            bits        <= '0;
            has_ext     <= 1'b0;
            nine_l      <= 1'b0;
            brk_cnt     <= '0;
            brk_done    <= 1'b0;
            frm_done    <= 1'b0;
            frm_stop_ok <= 1'b1;
            brk_hit     <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            brk_hit  <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rx) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rx) begin
                                state   <= S_DATA;
                                idx     <= '0;
                                has_ext <= par_en | nine_bit;
                                nine_l  <= nine_bit;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            bits[idx] <= rx;
                            if (idx == (has_ext ? LAST_E : LAST_D)) state <= S_STOP;
                            else                                    idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            frm_done    <= 1'b1;
                            frm_stop_ok <= rx;
                            if (rx) begin
                                state <= S_IDLE;
                            end else begin
                                state    <= S_BREAK;
                                brk_cnt  <= '0;
                                brk_done <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (rx) begin
                            state <= S_IDLE;
                        end else if (!brk_done) begin
                            if (brk_cnt == BRK_END) begin
                                brk_hit  <= 1'b1;
                                brk_done <= 1'b1;
                            end else begin
                                brk_cnt <= brk_cnt + 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Present the captured frame fields to the status logic.
    always_comb begin
        frm_data = bits[DATA_BITS-1:0];
        frm_ext  = has_ext & bits[DATA_BITS];
        frm_nine = nine_l;
        frm_par  = has_ext & ~nine_l;
    end

endmodule

// File: rtl/urx_status.sv
// Module: urx_status
// Holds the receive buffer, the sticky error flags, break detect and the
// attention mode, and applies the clear-on-read rules.
// Assumes: frm_done lasts one cycle and the frame fields are valid while it is high.
module urx_status
    import usart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx,
    input  logic                 frm_done,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_ext,
    input  logic                 frm_nine,
    input  logic                 frm_par,
    input  logic                 frm_stop_ok,
    input  logic                 brk_hit,
    input  logic [1:0]           par_sel,
    input  logic                 atn_set,
    input  logic                 rbuf_rd,
    input  logic                 stat_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_bit9,
    output logic                 rbuf_full,
    output logic                 pe,
    output logic                 fe,
    output logic                 ovr,
    output logic                 any_err,
    output logic                 bkd,
    output logic                 atn
);
    logic discard, load, addr_hit, par_bad, bkd_pend;

    // Decide whether the finished frame is stored and whether it is faulty.
    always_comb begin
        discard  = frm_done & frm_nine & atn & ~frm_ext;
        load     = frm_done & ~discard;
        addr_hit = frm_done & frm_nine & frm_ext;
        par_bad  = frm_par & (frm_ext != par_expected(^frm_data, par_sel));
        any_err  = pe | fe | ovr;
    end

    // Receive buffer, ninth bit and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rbuf_full <= 1'b0;
        end else begin
            if (load) begin
                rx_data <= frm_data;
                rx_bit9 <= frm_nine & frm_ext;
            end
            if (load)         rbuf_full <= 1'b1;
            else if (rbuf_rd) rbuf_full <= 1'b0;
        end
    end

    // Sticky error flags: a new event wins over a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe  <= 1'b0;
            fe  <= 1'b0;
            ovr <= 1'b0;
        end else begin
            if (load && par_bad)                      pe  <= 1'b1;
            else if (stat_rd)                         pe  <= 1'b0;
            if (load && !frm_stop_ok)                 fe  <= 1'b1;
            else if (stat_rd)                         fe  <= 1'b0;
            if (load && rbuf_full && !rbuf_rd)        ovr <= 1'b1;
            else if (stat_rd)                         ovr <= 1'b0;
        end
    end

    // Break flag with a clear that waits for the line to go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkd      <= 1'b0;
            bkd_pend <= 1'b0;
        end else if (brk_hit) begin
            bkd      <= 1'b1;
            bkd_pend <= 1'b0;
        end else if (bkd) begin
            if ((stat_rd || bkd_pend) && rx) begin
                bkd      <= 1'b0;
                bkd_pend <= 1'b0;
            end else if (stat_rd) begin
                bkd_pend <= 1'b1;
            end
        end
    end

    // Attention mode: set by its strobe, cleared by an address character.
    always_ff @(posedge clk) begin
        if (!rst_n)        atn <= 1'b0;
        else if (atn_set)  atn <= 1'b1;
        else if (addr_hit) atn <= 1'b0;
    end

endmodule

// File: rtl/usart_rx.sv
// Module: usart_rx (top)
// Asynchronous serial receiver: a frame sampler followed by buffer and status logic.
// Assumes: rx_i is already synchronised to clk and os_tick_i gives OVS ticks per bit.
module usart_rx #(
    parameter int OVS        = 16,
    parameter int DATA_BITS  = 8,
    parameter int BREAK_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    input  logic                 os_tick_i,
    input  logic                 par_en_i,
    input  logic [1:0]           par_sel_i,
    input  logic                 nine_bit_i,
    input  logic                 atn_set_i,
    input  logic                 rbuf_rd_i,
    input  logic                 stat_rd_i,
    output logic [DATA_BITS-1:0] rx_data_o,
    output logic                 rx_bit9_o,
    output logic                 rbuf_full_o,
    output logic                 par_err_o,
    output logic                 frm_err_o,
    output logic                 ovr_err_o,
    output logic                 any_err_o,
    output logic                 brk_det_o,
    output logic                 atn_mode_o
);
    logic                 frm_done, frm_ext, frm_nine, frm_par, frm_stop_ok, brk_hit;
    logic [DATA_BITS-1:0] frm_data;

    urx_sampler #(.OVS(OVS), .DATA_BITS(DATA_BITS), .BREAK_BITS(BREAK_BITS)) u_sampler (
        .clk(clk), .rst_n(rst_n), .rx(rx_i), .tick(os_tick_i),
        .par_en(par_en_i), .nine_bit(nine_bit_i),
        .frm_done(frm_done), .frm_data(frm_data), .frm_ext(frm_ext),
        .frm_nine(frm_nine), .frm_par(frm_par), .frm_stop_ok(frm_stop_ok),
        .brk_hit(brk_hit)
    );

    urx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk(clk), .rst_n(rst_n), .rx(rx_i),
        .frm_done(frm_done), .frm_data(frm_data), .frm_ext(frm_ext),
        .frm_nine(frm_nine), .frm_par(frm_par), .frm_stop_ok(frm_stop_ok),
        .brk_hit(brk_hit), .par_sel(par_sel_i), .atn_set(atn_set_i),
        .rbuf_rd(rbuf_rd_i), .stat_rd(stat_rd_i),
        .rx_data(rx_data_o), .rx_bit9(rx_bit9_o), .rbuf_full(rbuf_full_o),
        .pe(par_err_o), .fe(frm_err_o), .ovr(ovr_err_o), .any_err(any_err_o),
        .bkd(brk_det_o), .atn(atn_mode_o)
    );

endmodule

// File: rtl/usart_rx_checker.sv
// Module: usart_rx_checker
// Temporal checks that relate the sampler's frame events to the top-level flags.
// Assumes: bound into usart_rx, whose internal frame signals it observes.
module usart_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_i,
    input logic atn_set_i,
    input logic rbuf_rd_i,
    input logic stat_rd_i,
    input logic rbuf_full_o,
    input logic par_err_o,
    input logic frm_err_o,
    input logic ovr_err_o,
    input logic brk_det_o,
    input logic atn_mode_o,
    input logic frm_done,
    input logic frm_ext,
    input logic frm_nine,
    input logic frm_stop_ok
);
    p_store_sets_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !(frm_nine && atn_mode_o && !frm_ext) |=> rbuf_full_o);

    p_nine_no_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && frm_nine && !par_err_o |=> !par_err_o);

    p_bad_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !frm_nine && !frm_stop_ok |=> frm_err_o);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !frm_nine && rbuf_full_o && !rbuf_rd_i |=> ovr_err_o);

    p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i && !frm_done |=> !par_err_o && !frm_err_o && !ovr_err_o);

    p_break_holds_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det_o && !rx_i |=> brk_det_o);

    p_buf_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf_rd_i && !frm_done |=> !rbuf_full_o);

    p_addr_ends_atn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        atn_mode_o && frm_done && frm_nine && frm_ext && !atn_set_i |=> !atn_mode_o);

    p_atn_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        atn_mode_o && frm_done && frm_nine && !frm_ext && !rbuf_full_o |=> !rbuf_full_o);

endmodule

bind usart_rx usart_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .atn_set_i(atn_set_i),
    .rbuf_rd_i(rbuf_rd_i), .stat_rd_i(stat_rd_i), .rbuf_full_o(rbuf_full_o),
    .par_err_o(par_err_o), .frm_err_o(frm_err_o), .ovr_err_o(ovr_err_o),
    .brk_det_o(brk_det_o), .atn_mode_o(atn_mode_o), .frm_done(frm_done),
    .frm_ext(frm_ext), .frm_nine(frm_nine), .frm_stop_ok(frm_stop_ok)
);

// File: tb/usart_rx_bench.sv
// Bench for usart_rx: drives whole characters bit by bit with a tick every
// clock and compares every output against a behavioural model after each event.
module usart_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b1;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       nine = 1'b0;
    logic       atn_set = 1'b0;
    logic       rbuf_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rbuf_full, pe, fe, ovr, any_err, bkd, atn;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    // behavioural model state
    logic [7:0] m_data = 8'h00;
    bit m_b9, m_full, m_pe, m_fe, m_ovr, m_bkd, m_pend, m_atn;

    always #10 clk = ~clk;

    usart_rx u_usart_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .par_en_i(par_en), .par_sel_i(par_sel), .nine_bit_i(nine),
        .atn_set_i(atn_set), .rbuf_rd_i(rbuf_rd), .stat_rd_i(stat_rd),
        .rx_data_o(rx_data), .rx_bit9_o(rx_bit9), .rbuf_full_o(rbuf_full),
        .par_err_o(pe), .frm_err_o(fe), .ovr_err_o(ovr), .any_err_o(any_err),
        .brk_det_o(bkd), .atn_mode_o(atn)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "rx_data", int'(rx_data), int'(m_data));
        chk(req, "rx_bit9", int'(rx_bit9), int'(m_b9));
        chk(req, "rbuf_full", int'(rbuf_full), int'(m_full));
        chk(req, "par_err", int'(pe), int'(m_pe));
        chk(req, "frm_err", int'(fe), int'(m_fe));
        chk(req, "ovr_err", int'(ovr), int'(m_ovr));
        chk(req, "any_err", int'(any_err), int'(m_pe | m_fe | m_ovr));
        chk(req, "brk_det", int'(bkd), int'(m_bkd));
        chk(req, "atn_mode", int'(atn), int'(m_atn));
    endtask

    function automatic bit want_par(input logic [7:0] d, input logic [1:0] sel);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        case (sel)
            2'b00:   return (ones % 2 == 0);
            2'b01:   return (ones % 2 == 1);
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Model of one received character as the requirements describe it.
    task automatic model_frame(input logic [7:0] d, input bit ext, input bit stop_ok);
        if (nine && m_atn && !ext) return;
        if (nine && ext) m_atn = 0;
        if (m_full) m_ovr = 1;
        m_full = 1;
        m_data = d;
        m_b9 = nine ? ext : 1'b0;
        if (par_en && !nine && (ext != want_par(d, par_sel))) m_pe = 1;
        if (!stop_ok) m_fe = 1;
    endtask

    // Drive one frame; optionally pulse a status read in the cycle the frame completes.
    task automatic send(input logic [7:0] d, input bit ext, input bit stop_bit,
                        input bit rd_at_done, input int extra_low, input bit keep_low);
        rx = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = d[i];
            repeat (16) @(negedge clk);
        end
        if (nine || par_en) begin
            rx = ext;
            repeat (16) @(negedge clk);
        end
        rx = stop_bit;
        if (rd_at_done) begin
            repeat (9) @(negedge clk);
            stat_rd = 1'b1;
            @(negedge clk);
            stat_rd = 1'b0;
            repeat (6) @(negedge clk);
            m_pe = 0; m_fe = 0; m_ovr = 0;
        end else begin
            repeat (16) @(negedge clk);
        end
        model_frame(d, ext, stop_bit);
        if (!stop_bit) repeat (extra_low) @(negedge clk);
        if (!keep_low) rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic stat_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        m_pe = 0; m_fe = 0; m_ovr = 0;
        if (m_bkd) begin
            if (rx) m_bkd = 0;
            else    m_pend = 1;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic buf_read();
        rbuf_rd = 1'b1;
        @(negedge clk);
        rbuf_rd = 1'b0;
        m_full = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        compare_all("R12");

        // R1: plain eight-bit characters
        send(8'hA5, 0, 1, 0, 0, 0);
        compare_all("R1");
        buf_read();
        compare_all("R10");

        // R5: second character before the first was read
        send(8'h3C, 0, 1, 0, 0, 0);
        send(8'h81, 0, 1, 0, 0, 0);
        compare_all("R5");
        stat_read();
        compare_all("R6");
        buf_read();

        // R1: a short low glitch must not start a frame
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        compare_all("R1");

        // R2: each parity encoding with the right and the wrong bit
        par_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            par_sel = 2'(s);
            send(8'h5B, want_par(8'h5B, 2'(s)), 1, 0, 0, 0);
            compare_all("R2");
            buf_read();
            send(8'h5B, ~want_par(8'h5B, 2'(s)), 1, 0, 0, 0);
            compare_all("R2");
            stat_read();
            compare_all("R6");
            buf_read();
        end

        // R4: missing stop bit, line back high at once
        par_en = 1'b0;
        send(8'hC3, 0, 0, 0, 0, 0);
        compare_all("R4");
        stat_read();
        buf_read();

        // R7: status read lands on the cycle of a new framing error and overrun
        par_en = 1'b1;
        par_sel = 2'b01;
        send(8'h0F, ~want_par(8'h0F, 2'b01), 1, 0, 0, 0);
        compare_all("R2");
        send(8'hF1, want_par(8'hF1, 2'b01), 0, 1, 0, 0);
        compare_all("R7");
        stat_read();
        buf_read();

        // R3: nine-bit characters, parity setting ignored
        nine = 1'b1;
        send(8'h11, 1, 1, 0, 0, 0);
        compare_all("R3");
        buf_read();
        send(8'h22, 0, 1, 0, 0, 0);
        compare_all("R3");
        buf_read();

        // R11: attention mode
        atn_set = 1'b1;
        @(negedge clk);
        atn_set = 1'b0;
        m_atn = 1;
        @(negedge clk);
        compare_all("R11");
        send(8'h33, 0, 1, 0, 0, 0);
        compare_all("R11");
        send(8'h44, 1, 1, 0, 0, 0);
        compare_all("R11");
        buf_read();
        send(8'h55, 0, 1, 0, 0, 0);
        compare_all("R11");
        buf_read();

        // R8: short low after a bad stop bit is not a break
        nine = 1'b0;
        par_en = 1'b0;
        send(8'h00, 0, 0, 0, 80, 0);
        compare_all("R8");
        stat_read();
        buf_read();

        // R8, R9: long low, read while low, then line returns high
        send(8'h00, 0, 0, 0, 176, 1);
        m_bkd = 1;
        compare_all("R8");
        stat_read();
        compare_all("R9");
        rx = 1'b1;
        if (m_pend) begin m_bkd = 0; m_pend = 0; end
        repeat (3) @(negedge clk);
        compare_all("R9");
        buf_read();

        // R9: break ends without a read, flag stays until a read with line high
        send(8'h00, 0, 0, 0, 176, 0);
        m_bkd = 1;
        repeat (20) @(negedge clk);
        compare_all("R9");
        stat_read();
        compare_all("R9");
        buf_read();
        compare_all("R10");

        finish_run();
    end
endmodule